// File: doc/BRIEF.md
# Rotate and Shift Execution Unit

This unit carries out one rotate or shift on an 8-, 16- or 32-bit operand and returns the new operand value together with updated carry and overflow flags. A 3-bit operation code picks the function. A separate double-precision flag turns the unit into a funnel shifter, where a second operand supplies the bits that enter the destination. The shift count comes from one of three places: the fixed value one, the low byte of a count register, or an 8-bit immediate. Only the low five bits of the chosen count are used.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream through a single output register. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when it is being drained in the same cycle. A result stays on the output, unchanged, until `out_ready` accepts it. Operand fetch, writeback and opcode decode are handled outside the unit.

Top module: `rot_shift_unit`

## Requirements
- R1: With `in_dbl`=0, op 0 rotates the operand left and op 1 rotates it right, using only the operand's own bits (8, 16 or 32, chosen by `in_size`: 0=8, 1=16, 2 or 3=32). CF takes the last bit rotated out, which is the result LSB for a left rotate and the result MSB for a right rotate.
- R2: Op 2 (left) and op 3 (right) rotate a ring of width+1 bits made of CF above the operand MSB. The effective amount is the count modulo width+1, and CF out is the ring's top bit afterwards.
- R3: Ops 4 and 6 shift left and fill with zeros. CF takes the last bit shifted out, and is 0 when the count exceeds the width.
- R4: Op 5 shifts right and fills with zeros. Op 7 shifts right and fills with copies of the sign bit. CF takes the last bit shifted out. Beyond the width, CF is 0 for op 5 and the sign for op 7.
- R5: Count source `in_cnt_src` 0 selects the value 1, 1 selects `in_cnt_reg`, and 2 or 3 selects `in_imm`. Only bits [4:0] of the selected byte are used, and the source that is not selected has no effect.
- R6: When the masked count is zero, the result equals `in_a`, and CF and OF equal `in_cf` and `in_of`.
- R7: At a count of 1, OF is set as follows. For left rotates, left shifts and the double left shift it is result MSB XOR CF out. For ops 1 and 3 it is the XOR of the two top result bits. For op 5 it is the original MSB. For op 7 it is 0. For the double right shift it is result MSB XOR original MSB.
- R8: At any nonzero count other than 1, OF equals `in_of`.
- R9: With `in_dbl`=1, an even op shifts left and fills from the top of `in_b`, and an odd op shifts right and fills from the bottom of `in_b`. CF takes the last bit out. At 8-bit size the request leaves the operand and flags unchanged.
- R10: For 8- and 16-bit sizes, result bits above the operand width are copied from `in_a`.
- R11: `in_ready` is high when the output register is empty or is being drained. Each accepted request gives exactly one result, on the next edge. A stalled result holds steady until it is taken.
- R12: During reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_op | input | 3 | Operation code |
| in_dbl | input | 1 | Double-precision shift select |
| in_size | input | 2 | Operand size code |
| in_cnt_src | input | 2 | Count source select |
| in_cnt_reg | input | 8 | Count register low byte |
| in_imm | input | 8 | Immediate count byte |
| in_a | input | DW | Destination operand |
| in_b | input | DW | Fill operand for double shifts |
| in_cf | input | 1 | Incoming carry flag |
| in_of | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken when high with out_valid |
| out_result | output | DW | Shifted or rotated operand |
| out_cf | output | 1 | Updated carry flag |
| out_of | output | 1 | Updated overflow flag |

## Verification
The bench runs every operation, double-precision direction, size code and count value from 0 to 31 over operand patterns with both signs and every combination of incoming flags. Each result is compared with a model that moves the bits one step at a time. This exposes the main ways a design can go wrong. A carry rotate that drops CF from the ring would return the wrong value at counts of 9 and 17. Shifts past the width would leave a stale CF, or a SAR would fill with zeros. A zero count that still touched the flags would differ from the model, and an OF that was not held at counts other than 1 would not match `in_of`. The count is placed in the upper-bit-polluted byte of one source while the other source holds junk, so a missing mask or a wrong source gives the wrong amount. Random stalls check that a held result does not change.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int CNT_BITS = 5;
  localparam int SRC_W    = 8;

  typedef enum logic [2:0] {
    OP_ROTL  = 3'd0,
    OP_ROTR  = 3'd1,
    OP_RINGL = 3'd2,
    OP_RINGR = 3'd3,
    OP_SHL   = 3'd4,
    OP_SHR   = 3'd5,
    OP_SHL2  = 3'd6,
    OP_ASR   = 3'd7
  } rsu_op_e;

  typedef enum logic [1:0] {
    CSRC_ONE = 2'd0,
    CSRC_REG = 2'd1,
    CSRC_IMM = 2'd2,
    CSRC_IM2 = 2'd3
  } rsu_csrc_e;
endpackage

// File: rtl/rsu_count.sv
module rsu_count #(
  parameter int SW = 8,
  parameter int CB = 5
) (
  input  logic [1:0]    src,
  input  logic [SW-1:0] reg_byte,
  input  logic [SW-1:0] imm_byte,
  output logic [CB-1:0] cnt
);
  import rsu_pkg::*;

  always_comb begin
    unique case (rsu_csrc_e'(src))
      CSRC_ONE: cnt = CB'(1);
      CSRC_REG: cnt = reg_byte[CB-1:0];
      default:  cnt = imm_byte[CB-1:0];
    endcase
  end
endmodule

// File: rtl/rsu_lane.sv
module rsu_lane #(
  parameter int W  = 8,
  parameter int CB = 5
) (
  input  logic [2:0]    op,
  input  logic          dbl,
  input  logic [CB-1:0] cnt,
  input  logic [W-1:0]  x,
  input  logic [W-1:0]  y,
  input  logic          cf_in,
  input  logic          of_in,
  output logic [W-1:0]  res,
  output logic          cf_o,
  output logic          of_o
);
  import rsu_pkg::*;

  localparam int R      = W + 1;
  localparam bit DBL_OK = (W >= 16);

  logic [5:0]        rot_amt, ring_amt;
  logic [W-1:0]      rotl_v, rotr_v;
  logic [W:0]        ringl_v, ringr_v, shl_v, shr_v, dl_v, dr_v;
  logic signed [W:0] asr_v;
  logic              of_one;

  assign rot_amt  = 6'(int'(cnt) % W);
  assign ring_amt = 6'(int'(cnt) % R);

  assign rotl_v  = W'(({x, x} << rot_amt) >> W);
  assign rotr_v  = W'({x, x} >> rot_amt);
  assign ringl_v = R'(({cf_in, x, cf_in, x} << ring_amt) >> R);
  assign ringr_v = R'({cf_in, x, cf_in, x} >> ring_amt);
  assign shl_v   = {1'b0, x} << cnt;
  assign shr_v   = {x, 1'b0} >> cnt;
  assign asr_v   = $signed({x, 1'b0}) >>> cnt;
  assign dl_v    = R'(({1'b0, x, y} << cnt) >> W);
  assign dr_v    = R'({y, x, 1'b0} >> cnt);

  always_comb begin
    res    = x;
    cf_o   = cf_in;
    of_o   = of_in;
    of_one = of_in;
    if (cnt != '0 && !(dbl && !DBL_OK)) begin
      if (dbl) begin
        if (!op[0]) begin
          res    = dl_v[W-1:0];
          cf_o   = dl_v[W];
          of_one = dl_v[W-1] ^ dl_v[W];
        end else begin
          res    = dr_v[W:1];
          cf_o   = dr_v[0];
          of_one = dr_v[W] ^ x[W-1];
        end
      end else begin
        unique case (rsu_op_e'(op))
          OP_ROTL: begin
            res = rotl_v; cf_o = rotl_v[0]; of_one = rotl_v[W-1] ^ rotl_v[0];
          end
          OP_ROTR: begin
            res = rotr_v; cf_o = rotr_v[W-1]; of_one = rotr_v[W-1] ^ rotr_v[W-2];
          end
          OP_RINGL: begin
            res = ringl_v[W-1:0]; cf_o = ringl_v[W]; of_one = ringl_v[W-1] ^ ringl_v[W];
          end
          OP_RINGR: begin
            res = ringr_v[W-1:0]; cf_o = ringr_v[W]; of_one = ringr_v[W-1] ^ ringr_v[W-2];
          end
          OP_SHR: begin
            res = shr_v[W:1]; cf_o = shr_v[0]; of_one = x[W-1];
          end
          OP_ASR: begin
            res = asr_v[W:1]; cf_o = asr_v[0]; of_one = 1'b0;
          end
          default: begin
            res = shl_v[W-1:0]; cf_o = shl_v[W]; of_one = shl_v[W-1] ^ shl_v[W];
          end
        endcase
      end
      if (cnt == CB'(1)) of_o = of_one;
    end
  end
endmodule

// File: rtl/rot_shift_unit.sv
module rot_shift_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic          in_dbl,
  input  logic [1:0]    in_size,
  input  logic [1:0]    in_cnt_src,
  input  logic [7:0]    in_cnt_reg,
  input  logic [7:0]    in_imm,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic          in_cf,
  input  logic          in_of,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic          out_cf,
  output logic          out_of
);
  import rsu_pkg::*;

  localparam int NLANE = 3;
  localparam int CB    = CNT_BITS;

  logic [CB-1:0]    cnt;
  logic [DW-1:0]    lane_res [NLANE];
  logic [NLANE-1:0] lane_cf, lane_of;
  logic [1:0]       lane_sel;
  logic             take;

  rsu_count #(.SW(SRC_W), .CB(CB)) u_count (
    .src      (in_cnt_src),
    .reg_byte (in_cnt_reg),
    .imm_byte (in_imm),
    .cnt      (cnt)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = DW >> (NLANE - 1 - k);
    logic [LW-1:0] r;
    rsu_lane #(.W(LW), .CB(CB)) u_lane (
      .op    (in_op),
      .dbl   (in_dbl),
      .cnt   (cnt),
      .x     (in_a[LW-1:0]),
      .y     (in_b[LW-1:0]),
      .cf_in (in_cf),
      .of_in (in_of),
      .res   (r),
      .cf_o  (lane_cf[k]),
      .of_o  (lane_of[k])
    );
    if (LW < DW) begin : g_keep
      assign lane_res[k] = {in_a[DW-1:LW], r};
    end else begin : g_full
      assign lane_res[k] = r;
    end
  end

  assign lane_sel = (in_size > 2'd2) ? 2'd2 : in_size;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cf     <= 1'b0;
      out_of     <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= lane_res[lane_sel];
        out_cf     <= lane_cf[lane_sel];
        out_of     <= lane_of[lane_sel];
      end
    end
  end
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic          in_dbl,
  input logic [1:0]    in_size,
  input logic [1:0]    in_cnt_src,
  input logic [7:0]    in_cnt_reg,
  input logic [7:0]    in_imm,
  input logic [DW-1:0] in_a,
  input logic          in_cf,
  input logic          in_of,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_result,
  input logic          out_cf,
  input logic          out_of
);
  logic [7:0] src_byte;
  logic       acc;
  assign src_byte = (in_cnt_src == 2'd1) ? in_cnt_reg : in_imm;
  assign acc      = in_valid && in_ready;

  a_r12_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r11_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r11_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cf) && $stable(out_of));

  a_r6_zero_count_passes: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_cnt_src != 2'd0 && src_byte[4:0] == 5'd0 |=>
      out_result == $past(in_a) && out_cf == $past(in_cf) && out_of == $past(in_of));

  a_r7_asr_one_clears_of: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !in_dbl && in_op == 3'd7 && in_cnt_src == 2'd0 |=> !out_of);

  a_r10_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_size == 2'd0 |=> out_result[DW-1:DW/4] == $past(in_a[DW-1:DW/4]));
endmodule

bind rot_shift_unit rsu_checker #(.DW(DW)) u_rsu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .in_dbl     (in_dbl),
  .in_size    (in_size),
  .in_cnt_src (in_cnt_src),
  .in_cnt_reg (in_cnt_reg),
  .in_imm     (in_imm),
  .in_a       (in_a),
  .in_cf      (in_cf),
  .in_of      (in_of),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_cf     (out_cf),
  .out_of     (out_of)
);

// File: tb/rot_shift_unit_bench.sv
`timescale 1ns/1ps
module rot_shift_unit_bench;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic          in_dbl = 1'b0;
  logic [1:0]    in_size = '0;
  logic [1:0]    in_cnt_src = '0;
  logic [7:0]    in_cnt_reg = '0;
  logic [7:0]    in_imm = '0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          in_cf = 1'b0;
  logic          in_of = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_result;
  logic          out_cf;
  logic          out_of;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rot_shift_unit #(.DW(DW)) u_rot_shift_unit (.*);

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial reference
  task automatic model(input int op, input bit dbl, input int size, input logic [31:0] a, input logic [31:0] b,
                       input bit cf, input bit of, input int c,
                       output logic [31:0] r, output bit cfo, output bit ofo);
    int w = (size == 0) ? 8 : (size == 1) ? 16 : 32;
    logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    logic [31:0] x = a & mask;
    logic [31:0] y = b & mask;
    bit msb0 = x[w-1];
    bit cur = cf;
    bit t;
    if (c == 0 || (dbl && w == 8)) begin
      r = a; cfo = cf; ofo = of;
      return;
    end
    for (int i = 0; i < c; i++) begin
      if (dbl && op[0] == 1'b0) begin
        cur = x[w-1]; x = ((x << 1) | 32'(y[w-1])) & mask; y = (y << 1) & mask;
      end else if (dbl) begin
        cur = x[0]; x = (x >> 1) | (32'(y[0]) << (w - 1)); y = y >> 1;
      end else begin
        case (op)
          0: begin cur = x[w-1]; x = ((x << 1) | 32'(cur)) & mask; end
          1: begin cur = x[0]; x = (x >> 1) | (32'(cur) << (w - 1)); end
          2: begin t = x[w-1]; x = ((x << 1) | 32'(cur)) & mask; cur = t; end
          3: begin t = x[0]; x = (x >> 1) | (32'(cur) << (w - 1)); cur = t; end
          5: begin cur = x[0]; x = x >> 1; end
          7: begin cur = x[0]; x = (x >> 1) | (32'(x[w-1]) << (w - 1)); end
          default: begin cur = x[w-1]; x = (x << 1) & mask; end
        endcase
      end
    end
    cfo = cur;
    ofo = of;
    if (c == 1) begin
      if (dbl) ofo = op[0] ? (x[w-1] ^ msb0) : (x[w-1] ^ cur);
      else case (op)
        1, 3: ofo = x[w-1] ^ x[w-2];
        5: ofo = msb0;
        7: ofo = 1'b0;
        default: ofo = x[w-1] ^ cur;
      endcase
    end
    r = (a & ~mask) | x;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R12 reset valid", 32'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11 ready when empty", 32'(in_ready), 1);

    for (int m = 0; m < 10; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int c = 0; c < 32; c++) begin
          for (int p = 0; p < 4; p++) begin
            logic [31:0] a, b, er, held;
            bit ecf, eof, hcf, hof;
            int op = (m < 8) ? m : m - 4;
            bit dbl = (m >= 8);
            logic [7:0] junk = 8'((n * 37) | 8'h20) & 8'hE0;
            string tag;
            case (p)
              0: begin a = 32'h8000_0001; b = 32'hF0F0_0F0F; end
              1: begin a = 32'h1234_5678; b = 32'h8765_4321; end
              2: begin a = 32'hC3A5_96E9; b = 32'h0000_FFFF; end
              default: begin a = 32'h7FFF_8000; b = 32'h5555_AAAA; end
            endcase
            @(negedge clk);
            in_op = 3'(op); in_dbl = dbl; in_size = 2'(s);
            in_a = a; in_b = b; in_cf = p[0]; in_of = p[1];
            if (c == 1 && n % 2 == 0) begin
              in_cnt_src = 2'd0; in_cnt_reg = 8'h1D; in_imm = 8'h0B;
            end else if (n % 2 == 1) begin
              in_cnt_src = 2'd1; in_cnt_reg = junk | 8'(c); in_imm = 8'h17;
            end else begin
              in_cnt_src = (n % 4 == 0) ? 2'd2 : 2'd3; in_imm = junk | 8'(c); in_cnt_reg = 8'h0E;
            end
            in_valid = 1'b1; out_ready = 1'b0;
            model(op, dbl, s, a, b, p[0], p[1], c, er, ecf, eof);
            @(negedge clk);
            in_valid = 1'b0;
            held = out_result; hcf = out_cf; hof = out_of;
            for (int k = 0; k < n % 3; k++) begin
              @(negedge clk);
              check(out_valid && !in_ready && out_result == held && out_cf == hcf && out_of == hof,
                    "R11 stall hold", out_result, held);
            end
            if (c == 0) tag = "R6";
            else if (dbl) tag = "R9";
            else if (op < 2) tag = "R1";
            else if (op < 4) tag = "R2";
            else if (op == 5 || op == 7) tag = "R4";
            else tag = "R3";
            check(out_valid && out_result == er, $sformatf("%s R5 R10 result op=%0d dbl=%0d size=%0d cnt=%0d", tag, op, dbl, s, c),
                  out_result, er);
            check(out_cf == ecf, $sformatf("%s carry op=%0d dbl=%0d size=%0d cnt=%0d", tag, op, dbl, s, c),
                  32'(out_cf), 32'(ecf));
            check(out_of == eof, $sformatf("%s overflow op=%0d dbl=%0d size=%0d cnt=%0d", (c == 1) ? "R7" : "R8", op, dbl, s, c),
                  32'(out_of), 32'(eof));
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
            n++;
          end
        end
      end
    end
    check(out_valid == 1'b0, "R11 drained", 32'(out_valid), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule